// File: doc/BRIEF.md
# Software-Triggered One-Shot Strobe Timer

This block is a single timer channel. Software writes a count into it, and the block drives a one-clock active-low strobe on its output a fixed number of clocks later. Each count write starts a new delay. Rewriting the count while the delay is running restarts it from the new value. A gate input pauses the countdown but never touches the output. After the strobe, the down-counter keeps running and wraps through its full range, but it stays silent until software writes another count.

Software uses one write port of byte width. A write with the control flag set chooses the load format. The format decides whether a count is taken from one byte, the low byte or the high byte, or from a low byte followed by a high byte. A write with the control flag clear supplies a count byte. The count is twice the byte width. The byte width is a parameter.

Top module: `swstrobe_timer`

## Requirements
- R1: After reset, `out_n` is 1 and stays 1 until a count has been written. The reset load format is two-byte (code 3).
- R2: A control write with a nonzero format code in `wr_data[1:0]` has four effects. It stops the countdown, drops any pending load, forces `out_n` to 1 and returns the two-byte sequence to its low byte. No strobe follows until a new count is complete.
- R3: A count becomes complete on a clock edge. On the next edge the down-counter loads that count N. With `gate` held at 1, `out_n` is 0 for the clock that starts N edges after the load edge.
- R4: The strobe lasts exactly one clock. `out_n` returns to 1 on the next edge.
- R5: After the strobe, the counter keeps decrementing and wraps through its full range. It produces no further strobe until a new count is loaded.
- R6: A count completed while a countdown is running reloads the counter on the next edge. The strobe then comes N clocks after that reload.
- R7: Format code 3 (two-byte) takes the low byte first and the high byte second. The first byte alone starts no load. The second byte completes the count and triggers the load.
- R8: With format code 1 (low byte only), each byte write completes a count equal to that byte, with the upper byte zero. With format code 2 (high byte only), each byte write completes a count with that byte in the upper half and zero in the lower half.
- R9: With `gate` at 0, the counter holds its value, and `out_n` does not change because of the gate. A strobe that was due is postponed until the gate returns to 1 and the last decrement happens.
- R10: A count of 0 acts as the full range. The strobe comes 2^(2*BYTE_W) clocks after the load.
- R11: A control write with format code 0 is ignored. The format, the countdown and `out_n` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_ctrl | input | 1 | 1: control write (format in bits 1:0); 0: count byte |
| wr_data | input | BYTE_W | Write data |
| gate | input | 1 | Count enable: 1 counts, 0 holds |
| out_n | output | 1 | Active-low one-clock strobe |

## Verification
The bench builds the block with BYTE_W = 4, which gives a full count range of 256 clocks. At that size, the zero-count case and a complete wrap after the strobe each fit in a few hundred cycles. Both show that no second strobe appears. The two-byte sequence keeps its structure: a low byte stored first and a high byte that completes the count. So the byte-ordering and pointer-reset cases behave exactly as they would at a wider byte size.

// File: rtl/stb_pkg.sv
package stb_pkg;

    typedef enum logic [1:0] {
        FMT_NONE = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_BOTH = 2'b11
    } fmt_e;

    typedef struct packed {
        logic ctrl_wr;
        logic byte_wr;
        fmt_e new_fmt;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input logic en, input logic is_ctrl,
                                             input logic [1:0] low_bits);
        wr_cmd_t c;
        c.new_fmt = fmt_e'(low_bits);
        c.ctrl_wr = en && is_ctrl && (low_bits != 2'b00);
        c.byte_wr = en && !is_ctrl;
        return c;
    endfunction

endpackage

// File: rtl/stb_count_reg.sv
module stb_count_reg
    import stb_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              ld_o,
    output logic [CNT_W-1:0]  cr_o
);

    localparam logic [BYTE_W-1:0] ZERO_B = '0;

    fmt_e              fmt_q;
    logic              hi_next_q;
    logic [BYTE_W-1:0] low_q;
    logic [CNT_W-1:0]  cr_q;
    logic              ld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q     <= FMT_BOTH;
            hi_next_q <= 1'b0;
            low_q     <= '0;
            cr_q      <= '0;
            ld_q      <= 1'b0;
        end else begin
            ld_q <= 1'b0;
            if (cmd.ctrl_wr) begin
                fmt_q     <= cmd.new_fmt;
                hi_next_q <= 1'b0;
            end else if (cmd.byte_wr) begin
                case (fmt_q)
                    FMT_LO: begin
                        cr_q <= {ZERO_B, byte_in};
                        ld_q <= 1'b1;
                    end
                    FMT_HI: begin
                        cr_q <= {byte_in, ZERO_B};
                        ld_q <= 1'b1;
                    end
                    default: begin
                        if (!hi_next_q) begin
                            low_q     <= byte_in;
                            hi_next_q <= 1'b1;
                        end else begin
                            cr_q      <= {byte_in, low_q};
                            ld_q      <= 1'b1;
                            hi_next_q <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    assign ld_o = ld_q;
    assign cr_o = cr_q;

    // R7: the first byte of a two-byte count never produces a load
    p_first_byte_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.byte_wr && !cmd.ctrl_wr && fmt_q == FMT_BOTH && !hi_next_q) |=> !ld_q);

    // R2: a control write cancels any load request
    p_ctrl_drops_load_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.ctrl_wr |=> !ld_q);

endmodule

// File: rtl/stb_down_counter.sv
module stb_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] cr_i,
    input  logic             gate_i,
    output logic             out_n_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ce_q;
    logic             run_q;
    logic             arm_q;
    logic             out_q;
    logic             hit_zero;

    assign hit_zero = arm_q && (ce_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q  <= '0;
            run_q <= 1'b0;
            arm_q <= 1'b0;
            out_q <= 1'b1;
        end else begin
            out_q <= 1'b1;
            if (stop_i) begin
                run_q <= 1'b0;
                arm_q <= 1'b0;
            end else if (ld_i) begin
                ce_q  <= cr_i;
                run_q <= 1'b1;
                arm_q <= 1'b1;
            end else if (run_q && gate_i) begin
                ce_q <= ce_q - ONE;
                if (hit_zero) begin
                    out_q <= 1'b0;
                    arm_q <= 1'b0;
                end
            end
        end
    end

    assign out_n_o = out_q;

    // R3: the counter takes the count one edge after it is presented
    p_load_value_r3: assert property (@(posedge clk) disable iff (rst)
        (ld_i && !stop_i) |=> ce_q == $past(cr_i));

    // R4: the strobe is never wider than one clock
    p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
        !out_q |=> out_q);

    // R5: nothing fires once the strobe has been spent
    p_silent_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
        !arm_q |=> out_q);

    // R9: a low gate freezes the count
    p_gate_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q && !gate_i && !ld_i && !stop_i) |=> ce_q == $past(ce_q));

    // R2: a control write halts counting with the output high
    p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (out_q && !run_q));

endmodule

// File: rtl/swstrobe_timer.sv
module swstrobe_timer
    import stb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              gate,
    output logic              out_n
);

    localparam int CNT_W = 2 * BYTE_W;

    wr_cmd_t          cmd;
    logic             ld;
    logic [CNT_W-1:0] cr;

    assign cmd = decode_write(wr_en, wr_ctrl, wr_data[1:0]);

    stb_count_reg #(.BYTE_W(BYTE_W)) u_count_reg (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .byte_in (wr_data),
        .ld_o    (ld),
        .cr_o    (cr)
    );

    stb_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .stop_i  (cmd.ctrl_wr),
        .ld_i    (ld),
        .cr_i    (cr),
        .gate_i  (gate),
        .out_n_o (out_n)
    );

    // R1: output is high in the first cycle after reset
    p_reset_high_r1: assert property (@(posedge clk)
        $past(rst) |-> out_n);

endmodule

// File: tb/swstrobe_timer_bench.sv
module swstrobe_timer_bench;

    localparam int BW  = 4;
    localparam int MOD = 1 << (2 * BW);
    localparam int BASE = 1 << BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_ctrl = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic          gate = 1'b1;
    logic          out_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit live = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_out = 1, m_run = 0, m_arm = 0, m_fmt = 3, m_hi = 0;
    int m_pend = 0, m_ce = 0, m_cr = 0, m_low = 0;

    swstrobe_timer #(.BYTE_W(BW)) u_swstrobe_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .gate(gate), .out_n(out_n)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_out = 1; m_run = 0; m_arm = 0; m_fmt = 3; m_hi = 0;
            m_pend = 0; m_ce = 0; m_cr = 0; m_low = 0;
        end else begin
            int nxt;
            int d;
            nxt = 1;
            d = int'(wr_data);
            if (wr_en && wr_ctrl && (d % 4) != 0) begin
                m_run = 0; m_arm = 0;
            end else if (m_pend != 0) begin
                m_ce = m_cr; m_run = 1; m_arm = 1;
            end else if (m_run != 0 && gate) begin
                if (m_arm != 0 && m_ce == 1) begin
                    nxt = 0; m_arm = 0;
                end
                m_ce = (m_ce + MOD - 1) % MOD;
            end
            m_out = nxt;
            m_pend = 0;
            if (wr_en && wr_ctrl) begin
                if ((d % 4) != 0) begin
                    m_fmt = d % 4; m_hi = 0;
                end
            end else if (wr_en) begin
                if (m_fmt == 1) begin
                    m_cr = d; m_pend = 1;
                end else if (m_fmt == 2) begin
                    m_cr = d * BASE; m_pend = 1;
                end else if (m_hi == 0) begin
                    m_low = d; m_hi = 1;
                end else begin
                    m_cr = d * BASE + m_low; m_pend = 1; m_hi = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            checks++;
            if (out_n !== m_out[0]) begin
                failures++;
                $display("FAIL %s cycle-compare: out_n actual=%0b expected=%0d", cur_req, out_n, m_out);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input bit ctrl, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = ctrl; wr_data = BW'(val);
        @(negedge clk);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic wr16(input int val);
        wr(1'b0, val % BASE);
        wr(1'b0, val / BASE);
    endtask

    // negedges from now until out_n is low, then confirm one-clock width
    task automatic expect_strobe(input int n_exp, input string req);
        int w = 0;
        while (out_n === 1'b1 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        check(w == n_exp, req, "strobe delay", w, n_exp);
        @(negedge clk);
        check(out_n === 1'b1, "R4", "strobe width", int'(out_n), 1);
    endtask

    task automatic count_lows(input int span, input int exp, input string req);
        int lows = 0;
        for (int i = 0; i < span; i++) begin
            @(negedge clk);
            if (out_n !== 1'b1) lows++;
        end
        check(lows == exp, req, "low samples", lows, exp);
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        live = 1'b1;
        // R1: idle after reset
        cur_req = "R1";
        check(out_n === 1'b1, "R1", "reset out_n", int'(out_n), 1);
        count_lows(10, 0, "R1");
        // R3: two-byte default format, N=5 and N=1
        cur_req = "R3";
        wr16(5);
        expect_strobe(6, "R3");
        wr16(1);
        expect_strobe(2, "R3");
        // R6: retrigger during a running count
        cur_req = "R6";
        wr16(40);
        repeat (10) @(negedge clk);
        wr16(7);
        expect_strobe(8, "R6");
        // R7: lone first byte starts nothing
        cur_req = "R7";
        wr(1'b0, 3);
        count_lows(20, 0, "R7");
        wr(1'b0, 1);
        expect_strobe(20, "R7");
        // R8: single-byte formats
        cur_req = "R8";
        wr(1'b1, 1);
        wr(1'b0, 9);
        expect_strobe(10, "R8");
        wr(1'b1, 2);
        wr(1'b0, 1);
        expect_strobe(17, "R8");
        // R9: gate low right after load, then across a due strobe
        cur_req = "R9";
        wr(1'b1, 1);
        wr(1'b0, 6);
        gate = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(out_n === 1'b1, "R9", "out_n with gate low", int'(out_n), 1);
        end
        gate = 1'b1;
        expect_strobe(6, "R9");
        wr(1'b0, 3);
        repeat (3) @(negedge clk);
        gate = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(out_n === 1'b1, "R9", "held strobe", int'(out_n), 1);
        end
        gate = 1'b1;
        expect_strobe(1, "R9");
        // R10: zero count is full range
        cur_req = "R10";
        wr(1'b1, 3);
        wr16(0);
        expect_strobe(MOD + 1, "R10");
        // R5: wrap with no further strobe
        cur_req = "R5";
        count_lows(300, 0, "R5");
        // R2: control write halts a count and resets byte order
        cur_req = "R2";
        wr16(30);
        repeat (5) @(negedge clk);
        wr(1'b0, 3);
        wr(1'b1, 3);
        count_lows(60, 0, "R2");
        wr16(2);
        expect_strobe(3, "R2");
        // R11: format code 0 ignored
        cur_req = "R11";
        wr(1'b1, 1);
        wr(1'b0, 12);
        wr(1'b1, 0);
        expect_strobe(11, "R11");
        wr(1'b0, 5);
        expect_strobe(6, "R11");
        repeat (5) @(negedge clk);
        live = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule